// File: doc/BRIEF.md
# Flash Toggle-Bit Completion Poller

This block sits on the host side of a parallel NOR flash. Once a program or erase command has been written by other logic, a start pulse hands status checking to this controller. It reads the device status byte in pairs through a request/acknowledge read port. Between the two reads of a pair it compares the toggle bit (bit 6). It also watches the limit-exceeded flag (bit 5). When the outcome is settled, it reports completion, failure or a poll timeout.

When the toggle bit still moves while the limit flag is up, the controller makes one more pair of reads before it decides. The toggle bit may have stopped in the same moment the flag rose. If the toggle bit is still moving in that recheck, the controller reports failure and pulses a request for a reset-command write, so the device goes back to array reads. An abort input drops any check in progress. Every new check, and every pair within a check, begins with a fresh first read.

Top module: `toggle_poll_ctrl`

## Requirements
- R1: After reset, `rd_req_o`, `busy_o`, `done_o`, `fail_o`, `timeout_o` and `rst_cmd_o` are all low.
- R2: An accepted start raises `rd_req_o` and `busy_o` one cycle later. Each read request stays high until a cycle with `rd_ack_i` high, and `rd_data_i` is used only in such a cycle.
- R3: When bit 6 is equal in the two reads of a pair, the check ends with `done_o` high after exactly those reads. `done_o` stays high until the next start or abort.
- R4: When bit 6 differs within a pair and bit 5 of the second read is 0, the controller reads another pair.
- R5: When bit 6 differs within a pair and bit 5 of the second read is 1, one recheck pair is read, even if the poll limit has been reached. Equal bit 6 values in the recheck give `done_o`.
- R6: When bit 6 still differs in the recheck, `fail_o` goes high. `rst_cmd_o` is high for exactly one cycle, the first cycle of `fail_o`. No other outcome produces `rst_cmd_o`.
- R7: The first read of every pair is compared only with the second read of that same pair. No value stored from an earlier pair or an earlier check is reused.
- R8: `abort_i` returns the controller to idle on the next cycle, with every status output and `rd_req_o` low. It takes priority over `start_i`.
- R9: `max_polls_i` is sampled at start, with 0 taken as 1. After that many unsettled pairs with bit 5 clear, `timeout_o` goes high and no reset command is requested.
- R10: At most one of `busy_o`, `done_o`, `fail_o` and `timeout_o` is high in any cycle. A start while busy is ignored.
- R11: Bit 5 set together with equal bit 6 values in a pair gives `done_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a new status check |
| abort_i | input | 1 | Abandon the check and return to idle |
| max_polls_i | input | CNT_W | Limit on unsettled read pairs (0 means 1) |
| rd_req_o | output | 1 | Status read request |
| rd_ack_i | input | 1 | Read acknowledge; data valid in this cycle |
| rd_data_i | input | DATA_W | Status byte returned by the read |
| busy_o | output | 1 | Check in progress |
| done_o | output | 1 | Operation finished successfully |
| fail_o | output | 1 | Operation failed |
| timeout_o | output | 1 | Poll limit reached without a settled result |
| rst_cmd_o | output | 1 | One-cycle request to write the reset command |

## Verification
Every result register changes on the clock edge that samples the acknowledge of the deciding read, so `done_o`, `fail_o` or `timeout_o` is visible in the cycle after that acknowledge. `rst_cmd_o` appears in that same cycle. The bench samples at falling edges: it waits for the first falling edge at which a result is up, then compares the result, the number of acknowledged reads and the number of reset-command pulses against values worked out from the requirements. Cycle-exact behaviour is checked in directed cases. A request held without acknowledge must stay high at every falling edge. An abort must clear the outputs by the first falling edge after the clock edge that samples it.

// File: rtl/toggle_poll_ctrl.sv
module toggle_poll_ctrl #(
  parameter int DATA_W     = 8,
  parameter int TOGGLE_IDX = 6,
  parameter int LIMIT_IDX  = 5,
  parameter int CNT_W      = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              abort_i,
  input  logic [CNT_W-1:0]  max_polls_i,
  output logic              rd_req_o,
  input  logic              rd_ack_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              fail_o,
  output logic              timeout_o,
  output logic              rst_cmd_o
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  typedef enum logic [2:0] {
    S_IDLE, S_FIRST, S_SECOND, S_RE_FIRST, S_RE_SECOND, S_DONE, S_FAIL, S_TMO
  } state_t;

  state_t           st_q, st_d;
  logic             tog_q;
  logic [CNT_W-1:0] polls_q, lim_q;
  logic             rst_cmd_q;

  assign busy_o    = (st_q == S_FIRST) || (st_q == S_SECOND) ||
                     (st_q == S_RE_FIRST) || (st_q == S_RE_SECOND);
  assign rd_req_o  = busy_o;
  assign done_o    = (st_q == S_DONE);
  assign fail_o    = (st_q == S_FAIL);
  assign timeout_o = (st_q == S_TMO);
  assign rst_cmd_o = rst_cmd_q;

  wire take      = rd_req_o && rd_ack_i;
  wire tog_now   = rd_data_i[TOGGLE_IDX];
  wire lim_now   = rd_data_i[LIMIT_IDX];
  wire moved     = tog_now != tog_q;
  wire last_poll = (polls_q + ONE) >= lim_q;
  wire go        = start_i && !busy_o && !abort_i;

  always_comb begin
    st_d = st_q;
    if (abort_i) st_d = S_IDLE;
    else begin
      case (st_q)
        S_FIRST:     if (take) st_d = S_SECOND;
        S_SECOND:    if (take) begin
                       if (!moved)         st_d = S_DONE;
                       else if (lim_now)   st_d = S_RE_FIRST;
                       else if (last_poll) st_d = S_TMO;
                       else                st_d = S_FIRST;
                     end
        S_RE_FIRST:  if (take) st_d = S_RE_SECOND;
        S_RE_SECOND: if (take) st_d = moved ? S_FAIL : S_DONE;
        default:     if (start_i) st_d = S_FIRST;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= S_IDLE;
      tog_q     <= 1'b0;
      polls_q   <= '0;
      lim_q     <= ONE;
      rst_cmd_q <= 1'b0;
    end else begin
      st_q      <= st_d;
      rst_cmd_q <= (st_d == S_FAIL) && (st_q != S_FAIL);
      if (abort_i || go) tog_q <= 1'b0;
      else if (take && (st_q == S_FIRST || st_q == S_RE_FIRST)) tog_q <= tog_now;
      if (go) begin
        polls_q <= '0;
        lim_q   <= (max_polls_i == '0) ? ONE : max_polls_i;
      end else if (take && st_q == S_SECOND && moved && !lim_now && !last_poll)
        polls_q <= polls_q + ONE;
    end
  end

  AST_ONE_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({busy_o, done_o, fail_o, timeout_o})); // R10
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_o && !rd_ack_i && !abort_i |=> rd_req_o); // R2
  AST_RSTCMD_ON_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
    rst_cmd_o |-> $rose(fail_o)); // R6
  AST_RSTCMD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rst_cmd_o |=> !rst_cmd_o); // R6
  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    abort_i |=> !busy_o && !done_o && !fail_o && !timeout_o); // R8
  AST_DONE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && !start_i && !abort_i |=> done_o); // R3
  AST_POLL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> polls_q < lim_q); // R9

endmodule

// File: tb/toggle_poll_ctrl_tb.sv
module toggle_poll_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0, abort_i = 1'b0, rd_ack_i = 1'b0;
  logic [15:0] max_polls_i = 16'd8;
  logic [7:0]  rd_data_i = 8'h00;
  logic        rd_req_o, busy_o, done_o, fail_o, timeout_o, rst_cmd_o;

  always #5 clk = ~clk;

  toggle_poll_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .abort_i(abort_i),
    .max_polls_i(max_polls_i), .rd_req_o(rd_req_o), .rd_ack_i(rd_ack_i),
    .rd_data_i(rd_data_i), .busy_o(busy_o), .done_o(done_o), .fail_o(fail_o),
    .timeout_o(timeout_o), .rst_cmd_o(rst_cmd_o));

  int n_chk = 0, n_bad = 0;
  int reads = 0, pulses = 0, excl_bad = 0;
  logic [47:0] rsp_seq = '0;
  logic resp_en = 1'b1;

  // result codes: 1 done, 2 fail, 3 timeout
  localparam int NV = 10;
  localparam logic [47:0] V_SEQ [NV] = '{
    48'h0000_0000_0000, 48'h4040_0000_0000, 48'h4060_0000_0000,
    48'h0040_4040_0000, 48'h0060_4040_0000, 48'h4020_0040_0000,
    48'h0040_4000_0000, 48'h0040_0000_0000, 48'h0040_0000_0000,
    48'h0060_0000_0000};
  localparam int V_LIM [NV] = '{8, 8, 8, 8, 8, 8, 2, 8, 0, 1};
  localparam int V_RES [NV] = '{1, 1, 1, 1, 1, 2, 3, 1, 3, 1};
  localparam int V_RDS [NV] = '{2, 2, 2, 4, 4, 4, 4, 4, 2, 4};

  function automatic string tag(int i);
    case (i)
      0, 1: return "R3";
      2:    return "R11";
      3:    return "R4";
      4:    return "R5";
      5:    return "R6";
      6, 8: return "R9";
      7:    return "R7";
      default: return "R5";
    endcase
  endfunction

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  initial forever begin
    @(negedge clk);
    if (rst_cmd_o) pulses++;
    if (int'(busy_o) + int'(done_o) + int'(fail_o) + int'(timeout_o) > 1) excl_bad++;
    if (rd_req_o && !rd_ack_i && resp_en) begin
      rd_data_i = (reads < 6) ? rsp_seq[47 - 8*reads -: 8] : 8'h00;
      rd_ack_i = 1'b1;
      reads++;
    end else rd_ack_i = 1'b0;
  end

  function automatic int result();
    return done_o ? 1 : fail_o ? 2 : timeout_o ? 3 : 0;
  endfunction

  task automatic launch(logic [47:0] s, int lim);
    @(negedge clk);
    rsp_seq = s; reads = 0; pulses = 0;
    max_polls_i = 16'(lim);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic wait_result();
    for (int k = 0; k < 300; k++) begin
      if (result() != 0) break;
      @(negedge clk);
    end
    @(negedge clk);
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", int'({rd_req_o, busy_o, done_o, fail_o, timeout_o, rst_cmd_o}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", int'({rd_req_o, busy_o, done_o, fail_o, timeout_o, rst_cmd_o}), 0);

    for (int i = 0; i < NV; i++) begin
      launch(V_SEQ[i], V_LIM[i]);
      wait_result();
      check(tag(i), result(), V_RES[i]);
      check(tag(i), reads, V_RDS[i]);
      check("R6", pulses, (V_RES[i] == 2) ? 1 : 0);
    end

    // R3: done stays up while idle
    repeat (5) @(negedge clk);
    check("R3", int'(done_o), 1);

    // R2: request held without acknowledge; R10: start while busy ignored
    resp_en = 1'b0;
    launch(48'h0040_4040_0000, 8);
    check("R2", int'({rd_req_o, busy_o}), 3);
    repeat (4) @(negedge clk);
    check("R2", int'(rd_req_o), 1);
    start_i = 1'b1; @(negedge clk); start_i = 1'b0;
    resp_en = 1'b1;
    wait_result();
    check("R10", result(), 1);
    check("R10", reads, 4);

    // R8: abort mid-check, then a fresh check (R7) with no reuse of stored bit
    resp_en = 1'b0;
    launch(48'h4000_0000_0000, 8);
    resp_en = 1'b1;
    @(negedge clk); @(negedge clk);
    resp_en = 1'b0;
    abort_i = 1'b1; start_i = 1'b1;
    @(negedge clk);
    abort_i = 1'b0; start_i = 1'b0;
    check("R8", int'({rd_req_o, busy_o, done_o, fail_o, timeout_o}), 0);
    resp_en = 1'b1;
    launch(48'h0000_0000_0000, 8);
    wait_result();
    check("R7", result(), 1);
    check("R7", reads, 2);

    check("R10", excl_bad, 0);
    finish_up();
  end
endmodule